// File: doc/BRIEF.md
# Display Power-Up and Identity Check Sequencer

This block brings an external display driver module out of power-up and confirms that the expected part is attached before any configuration is sent to it. It controls two active-low lines, a write-protect line and a reset line. When it receives a start request, it pulses these lines in a fixed timed order. It then acts as master on a simple command/parameter strobe bus. Over that bus it writes two unlock commands, issues an identity command, waits, and discards one read. It then reads four further words and builds a 32-bit identity code from them.

The assembled code is compared with a fixed expected value. The block ends each run with a one-cycle done pulse and a pass flag, and then returns to idle. A fail means that no valid device is present, and the system must not go on to configure the panel. All waits are derived from a clock-frequency parameter in kHz. A time divisor parameter shrinks every wait so that short simulations are possible.

Top module: `disp_id_seq`

## Requirements
- R1: During and after system reset, lcdProtN and lcdRstN are 0, busWr, busRd and done are 0, and pass is 0.
- R2: A start accepted in idle drives both lines low for one cycle. lcdProtN then goes high, and lcdRstN rises exactly T_RST cycles later, with lcdProtN still high.
- R3: lcdProtN falls exactly T_SET cycles after lcdRstN rises. The first bus write comes exactly T_PRE cycles after that fall.
- R4: Each wait has a cycle count of max(1, floor(CLK_KHZ*us / (1000*TIME_DIV))). The us values are 1100 for T_RST, 10 for T_SET, 20000 for T_PRE and 50000 for T_ID.
- R5: The writes are, in order, command 0xB0, parameter 0x00, command 0xB1, parameter 0x00 and command 0xBF. busRs is 0 for a command and 1 for a parameter. The value is on busDout[7:0], and the upper bits of busDout are 0 for commands. Each strobe lasts one cycle and is followed by one idle cycle, so consecutive writes are 2 cycles apart.
- R6: The first read strobe comes exactly 2+T_ID cycles after the 0xBF strobe. Exactly five reads follow, each with busRs=1 and spaced 2 cycles apart.
- R7: The data of the first read is discarded. In each of the next four reads only busDin[7:0] is used, and these bytes fill the code from the most significant byte down.
- R8: done is high for exactly one cycle, 3 cycles after the last read strobe. pass is 1 exactly when the code equals EXPECT_ID (default 0x01221517). pass keeps its value until the next accepted start clears it.
- R9: A start while a sequence is running is ignored. After every run, whether it passes or fails, the block is idle with lcdRstN=1 and lcdProtN=0, and it accepts a new start.
- R10: No bus strobe occurs while lcdRstN is low, and busWr and busRd are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| sysRstN | input | 1 | Asynchronous active-low system reset |
| start | input | 1 | Request to run the sequence, taken only when idle |
| lcdProtN | output | 1 | Active-low write-protect line to the module |
| lcdRstN | output | 1 | Active-low reset line to the module |
| busRs | output | 1 | Register select: 0 for a command, 1 for a parameter |
| busWr | output | 1 | One-cycle write strobe |
| busRd | output | 1 | One-cycle read strobe; busDin is sampled on the same edge |
| busDout | output | DATA_W | Write data |
| busDin | input | DATA_W | Read data |
| done | output | 1 | One-cycle pulse at the end of a run |
| pass | output | 1 | Identity comparison result |

## Verification
Some properties are checked by assertions on every cycle. These are the mutual exclusion of the strobes, the absence of bus traffic while the module is held in reset, the protect line being high when reset is released, parameter select on reads, zero upper bits on command writes, the single-cycle done pulse, and the low byte of each captured read landing in the code. Other behaviour can only be shown by the bench scenarios. This covers the exact wait lengths between line edges and bus phases, the full order of writes checked against a scoreboard, the byte order of the assembled code under junk upper bits, detection of a mismatch, and a start issued mid-run being ignored.

// File: rtl/disp_id_pkg.sv
package disp_id_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_HOLD, ST_PROT_HI, ST_RST_REL, ST_PROT_LO,
    ST_WR, ST_ID_WAIT, ST_RD, ST_CHECK
  } seqState_t;

  typedef enum logic [1:0] {
    DLY_RST, DLY_SET, DLY_PRE, DLY_ID
  } dlySel_t;

  typedef struct packed {
    logic    ldDelay;
    dlySel_t delaySel;
    logic    clrId;
    logic    capture;
  } ctlStrb_t;

  localparam int unsigned NUM_WR = 5;
  localparam int unsigned NUM_RD = 5;

endpackage

// File: rtl/disp_id_dpath.sv
module disp_id_dpath
  import disp_id_pkg::*;
#(
  parameter int unsigned CLK_KHZ   = 125000,
  parameter int unsigned TIME_DIV  = 1,
  parameter int unsigned DATA_W    = 18,
  parameter logic [31:0] EXPECT_ID = 32'h0122_1517
) (
  input  logic              clk,
  input  logic              sysRstN,
  input  ctlStrb_t          strb,
  input  logic [DATA_W-1:0] busDin,
  output logic              delayDone,
  output logic              idMatch
);

  localparam longint unsigned DEN = 64'(1000) * 64'(TIME_DIV);

  function automatic longint unsigned toCyc(input longint unsigned us);
    longint unsigned v;
    v = (64'(CLK_KHZ) * us) / DEN;
    return (v == 0) ? 64'd1 : v;
  endfunction

  localparam longint unsigned N_RST = toCyc(1100);
  localparam longint unsigned N_SET = toCyc(10);
  localparam longint unsigned N_PRE = toCyc(20000);
  localparam longint unsigned N_ID  = toCyc(50000);
  localparam int unsigned     CNT_W = $clog2(N_ID + 1);

  logic [CNT_W-1:0] cnt;
  logic [31:0]      idWord;

  // wait counter: loaded with N-1 so the wait state lasts N cycles
  always_ff @(posedge clk or negedge sysRstN) begin
    if (!sysRstN) begin
      cnt <= '0;
    end else if (strb.ldDelay) begin
      case (strb.delaySel)
        DLY_RST: cnt <= CNT_W'(N_RST - 1);
        DLY_SET: cnt <= CNT_W'(N_SET - 1);
        DLY_PRE: cnt <= CNT_W'(N_PRE - 1);
        default: cnt <= CNT_W'(N_ID - 1);
      endcase
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign delayDone = (cnt == '0);

  // identity word: bytes arrive most significant first
  always_ff @(posedge clk or negedge sysRstN) begin
    if (!sysRstN) begin
      idWord <= '0;
    end else if (strb.clrId) begin
      idWord <= '0;
    end else if (strb.capture) begin
      idWord <= {idWord[23:0], busDin[7:0]};
    end
  end

  assign idMatch = (idWord == EXPECT_ID);

  p_capture_low_byte_r7: assert property (@(posedge clk) disable iff (!sysRstN)
    strb.capture |=> idWord[7:0] == $past(busDin[7:0]));

  p_capture_shift_r7: assert property (@(posedge clk) disable iff (!sysRstN)
    strb.capture |=> idWord[15:8] == $past(idWord[7:0]));

endmodule

// File: rtl/disp_id_ctrl.sv
module disp_id_ctrl
  import disp_id_pkg::*;
#(
  parameter int unsigned DATA_W = 18
) (
  input  logic              clk,
  input  logic              sysRstN,
  input  logic              start,
  input  logic              delayDone,
  input  logic              idMatch,
  output ctlStrb_t          strb,
  output logic              lcdProtN,
  output logic              lcdRstN,
  output logic              busRs,
  output logic              busWr,
  output logic              busRd,
  output logic [DATA_W-1:0] busDout,
  output logic              done,
  output logic              pass
);

  localparam int unsigned IDX_W = $clog2(NUM_WR > NUM_RD ? NUM_WR : NUM_RD);

  seqState_t        state, nxt;
  logic [IDX_W-1:0] idx;
  logic             phase;
  logic             lastOp;

  function automatic logic [7:0] wrByte(input logic [IDX_W-1:0] i);
    case (i)
      0:       return 8'hB0;
      2:       return 8'hB1;
      4:       return 8'hBF;
      default: return 8'h00;
    endcase
  endfunction

  assign lastOp = phase && (idx == IDX_W'((state == ST_WR) ? NUM_WR - 1 : NUM_RD - 1));

  always_comb begin
    nxt  = state;
    strb = '0;
    case (state)
      ST_IDLE: if (start) begin
        nxt = ST_HOLD;
        strb.clrId = 1'b1;
      end
      ST_HOLD: begin
        nxt = ST_PROT_HI;
        strb.ldDelay = 1'b1;
        strb.delaySel = DLY_RST;
      end
      ST_PROT_HI: if (delayDone) begin
        nxt = ST_RST_REL;
        strb.ldDelay = 1'b1;
        strb.delaySel = DLY_SET;
      end
      ST_RST_REL: if (delayDone) begin
        nxt = ST_PROT_LO;
        strb.ldDelay = 1'b1;
        strb.delaySel = DLY_PRE;
      end
      ST_PROT_LO: if (delayDone) nxt = ST_WR;
      ST_WR: if (lastOp) begin
        nxt = ST_ID_WAIT;
        strb.ldDelay = 1'b1;
        strb.delaySel = DLY_ID;
      end
      ST_ID_WAIT: if (delayDone) nxt = ST_RD;
      ST_RD: begin
        strb.capture = !phase && (idx != '0);
        if (lastOp) nxt = ST_CHECK;
      end
      ST_CHECK: nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge sysRstN) begin
    if (!sysRstN) begin
      state   <= ST_IDLE;
      idx     <= '0;
      phase   <= 1'b0;
      lcdRstN <= 1'b0;
      done    <= 1'b0;
      pass    <= 1'b0;
    end else begin
      state <= nxt;
      done  <= (state == ST_CHECK);
      if (state == ST_WR || state == ST_RD) begin
        phase <= !phase;
        if (phase) idx <= (lastOp) ? '0 : idx + 1'b1;
      end else begin
        phase <= 1'b0;
        idx   <= '0;
      end
      if (state == ST_IDLE && start) begin
        lcdRstN <= 1'b0;
        pass    <= 1'b0;
      end else if (state == ST_PROT_HI && delayDone) begin
        lcdRstN <= 1'b1;
      end
      if (state == ST_CHECK) pass <= idMatch;
    end
  end

  assign lcdProtN = (state == ST_PROT_HI) || (state == ST_RST_REL);
  assign busWr    = (state == ST_WR) && !phase;
  assign busRd    = (state == ST_RD) && !phase;
  assign busRs    = (state == ST_WR) ? idx[0] : (state == ST_RD);
  assign busDout  = busWr ? DATA_W'(wrByte(idx)) : '0;

  p_strobe_mutex_r10: assert property (@(posedge clk) disable iff (!sysRstN)
    !(busWr && busRd));

  p_no_bus_in_reset_r10: assert property (@(posedge clk) disable iff (!sysRstN)
    !lcdRstN |-> !busWr && !busRd);

  p_prot_high_at_release_r2: assert property (@(posedge clk) disable iff (!sysRstN)
    $rose(lcdRstN) |-> lcdProtN);

  p_read_is_param_r6: assert property (@(posedge clk) disable iff (!sysRstN)
    busRd |-> busRs);

  p_cmd_upper_zero_r5: assert property (@(posedge clk) disable iff (!sysRstN)
    (busWr && !busRs) |-> busDout[DATA_W-1:8] == '0);

  p_done_single_r8: assert property (@(posedge clk) disable iff (!sysRstN)
    done |=> !done);

endmodule

// File: rtl/disp_id_seq.sv
module disp_id_seq
  import disp_id_pkg::*;
#(
  parameter int unsigned CLK_KHZ   = 125000,
  parameter int unsigned TIME_DIV  = 1,
  parameter int unsigned DATA_W    = 18,
  parameter logic [31:0] EXPECT_ID = 32'h0122_1517
) (
  input  logic              clk,
  input  logic              sysRstN,
  input  logic              start,
  output logic              lcdProtN,
  output logic              lcdRstN,
  output logic              busRs,
  output logic              busWr,
  output logic              busRd,
  output logic [DATA_W-1:0] busDout,
  input  logic [DATA_W-1:0] busDin,
  output logic              done,
  output logic              pass
);

  ctlStrb_t strb;
  logic     delayDone;
  logic     idMatch;

  disp_id_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .sysRstN(sysRstN), .start(start),
    .delayDone(delayDone), .idMatch(idMatch), .strb(strb),
    .lcdProtN(lcdProtN), .lcdRstN(lcdRstN), .busRs(busRs),
    .busWr(busWr), .busRd(busRd), .busDout(busDout),
    .done(done), .pass(pass)
  );

  disp_id_dpath #(
    .CLK_KHZ(CLK_KHZ), .TIME_DIV(TIME_DIV),
    .DATA_W(DATA_W), .EXPECT_ID(EXPECT_ID)
  ) u_dpath (
    .clk(clk), .sysRstN(sysRstN), .strb(strb), .busDin(busDin),
    .delayDone(delayDone), .idMatch(idMatch)
  );

endmodule

// File: tb/sim_disp_id_seq.sv
module sim_disp_id_seq;

  localparam int unsigned CLK_KHZ  = 125000;
  localparam int unsigned TIME_DIV = 1000;
  localparam int unsigned DW       = 18;

  typedef struct {
    bit          isRd;
    bit          rs;
    logic [17:0] data;
  } busItem_t;

  function automatic longint expCyc(input longint us);
    longint v;
    v = (longint'(CLK_KHZ) * us) / (1000 * longint'(TIME_DIV));
    return (v == 0) ? 1 : v;
  endfunction

  logic clk = 1'b0;
  logic sysRstN = 1'b0;
  logic start = 1'b0;
  logic lcdProtN, lcdRstN, busRs, busWr, busRd, done, pass;
  logic [DW-1:0] busDout, busDin;

  logic [DW-1:0] rdData [5];
  int   rdIdx = 0;
  logic rdClr = 1'b0;

  int nChecks = 0;
  int nFail   = 0;
  longint cyc = 0;

  busItem_t expQ [$];
  longint tProtRise, tRstRise, tProtFall, tFirstWr, tBf, tFirstRd, tLastRd, tDone;
  int  doneCount = 0;
  bit  firstWrSeen, firstRdSeen;
  logic prevProt = 1'b0, prevRst = 1'b0;

  always #4 clk = ~clk;

  disp_id_seq #(.CLK_KHZ(CLK_KHZ), .TIME_DIV(TIME_DIV), .DATA_W(DW)) u0 (
    .clk(clk), .sysRstN(sysRstN), .start(start),
    .lcdProtN(lcdProtN), .lcdRstN(lcdRstN), .busRs(busRs),
    .busWr(busWr), .busRd(busRd), .busDout(busDout), .busDin(busDin),
    .done(done), .pass(pass)
  );

  assign busDin = rdData[rdIdx];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rdClr) rdIdx <= 0;
    else if (busRd && rdIdx < 4) rdIdx <= rdIdx + 1;
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // monitor: pops expected transfers and logs event times
  always @(negedge clk) begin
    if (sysRstN) begin
      if (busWr || busRd) begin
        if (expQ.size() == 0) begin
          chk(1'b0, "R9 unexpected bus transfer", {busWr, busRd}, 0);
        end else begin
          busItem_t it;
          it = expQ.pop_front();
          chk(it.isRd == busRd, "R5 transfer kind", busRd, it.isRd);
          chk(it.rs == busRs, "R5 register select", busRs, it.rs);
          if (!it.isRd) chk(busDout == it.data, "R5 write data", busDout, it.data);
        end
        chk(lcdRstN == 1'b1, "R10 strobe with reset low", lcdRstN, 1);
        if (busWr && !firstWrSeen) begin firstWrSeen = 1; tFirstWr = cyc; end
        if (busWr && busDout == 18'h000BF && !busRs) tBf = cyc;
        if (busRd && !firstRdSeen) begin firstRdSeen = 1; tFirstRd = cyc; end
        if (busRd) tLastRd = cyc;
      end
      if (lcdProtN && !prevProt) tProtRise = cyc;
      if (!lcdProtN && prevProt) tProtFall = cyc;
      if (lcdRstN && !prevRst) tRstRise = cyc;
      if (done) begin doneCount++; tDone = cyc; end
    end
    prevProt = lcdProtN;
    prevRst  = lcdRstN;
  end

  task automatic pushExpected();
    logic [7:0] wb [5];
    wb = '{8'hB0, 8'h00, 8'hB1, 8'h00, 8'hBF};
    for (int i = 0; i < 5; i++) expQ.push_back('{isRd: 0, rs: (i % 2 == 1), data: 18'(wb[i])});
    for (int i = 0; i < 5; i++) expQ.push_back('{isRd: 1, rs: 1, data: 18'h0});
  endtask

  task automatic runSeq(input logic [17:0] d0, d1, d2, d3, d4, input bit expPass,
                        input bit poke, input string tag);
    int startDone;
    int guard;
    rdData[0] = d0; rdData[1] = d1; rdData[2] = d2; rdData[3] = d3; rdData[4] = d4;
    @(negedge clk); rdClr = 1'b1;
    @(negedge clk); rdClr = 1'b0;
    firstWrSeen = 0; firstRdSeen = 0;
    pushExpected();
    startDone = doneCount;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    // R2: hold cycle with both lines low, pass cleared by start (R8)
    chk(!lcdProtN && !lcdRstN, {"R2 hold both low ", tag}, {lcdProtN, lcdRstN}, 0);
    chk(pass == 1'b0, {"R8 pass cleared at start ", tag}, pass, 0);
    if (poke) begin
      repeat (300) @(negedge clk);
      start = 1'b1; @(negedge clk); start = 1'b0;
    end
    guard = 0;
    while (doneCount == startDone && guard < 30000) begin
      @(negedge clk); guard++;
    end
    chk(doneCount == startDone + 1, {"R8 done seen ", tag}, doneCount - startDone, 1);
    chk(tRstRise - tProtRise == expCyc(1100), {"R2 R4 protect-high to reset release ", tag},
        tRstRise - tProtRise, expCyc(1100));
    chk(tProtFall - tRstRise == expCyc(10), {"R3 R4 settle wait ", tag},
        tProtFall - tRstRise, expCyc(10));
    chk(tFirstWr - tProtFall == expCyc(20000), {"R3 R4 pre-access wait ", tag},
        tFirstWr - tProtFall, expCyc(20000));
    chk(tBf - tFirstWr == 8, {"R5 write spacing ", tag}, tBf - tFirstWr, 8);
    chk(tFirstRd - tBf == 2 + expCyc(50000), {"R6 R4 id wait ", tag},
        tFirstRd - tBf, 2 + expCyc(50000));
    chk(tLastRd - tFirstRd == 8, {"R6 read spacing ", tag}, tLastRd - tFirstRd, 8);
    chk(tDone - tLastRd == 3, {"R8 done timing ", tag}, tDone - tLastRd, 3);
    chk(pass == expPass, {"R7 R8 pass result ", tag}, pass, expPass);
    repeat (40) @(negedge clk);
    chk(doneCount == startDone + 1, {"R9 single done, busy start ignored ", tag},
        doneCount - startDone, 1);
    chk(expQ.size() == 0, {"R6 all transfers consumed ", tag}, expQ.size(), 0);
    chk(lcdRstN && !lcdProtN, {"R9 idle line levels ", tag}, {lcdRstN, lcdProtN}, 2'b10);
    chk(pass == expPass, {"R8 pass held ", tag}, pass, expPass);
  endtask

  initial begin
    #(8 * 200000);
    nChecks++; nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  %0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    rdData = '{default: '0};
    repeat (3) @(negedge clk);
    // R1: state held in reset
    chk(!lcdProtN && !lcdRstN, "R1 lines in reset", {lcdProtN, lcdRstN}, 0);
    chk(!busWr && !busRd && !done && !pass, "R1 outputs in reset",
        {busWr, busRd, done, pass}, 0);
    sysRstN = 1'b1;
    repeat (5) @(negedge clk);
    chk(!lcdProtN && !lcdRstN && !busWr && !busRd && !done,
        "R1 idle after reset", {lcdProtN, lcdRstN, busWr, busRd, done}, 0);
    // R7: dummy word and upper bits are junk; correct code
    runSeq(18'h3FFAA, 18'h3FF01, 18'h12322, 18'h00015, 18'h2AA17, 1'b1, 1'b0, "match");
    // R8 R9: byte order swapped, with a start pulse during the run
    runSeq(18'h00001, 18'h00001, 18'h00022, 18'h00017, 18'h00015, 1'b0, 1'b1, "swapped");
    // R8: last byte off by one
    runSeq(18'h00000, 18'h00001, 18'h00022, 18'h00015, 18'h00016, 1'b0, 1'b0, "offbyone");
    // R9: new start accepted after a fail; dummy word carries the code
    runSeq(18'h01221, 18'h10001, 18'h20022, 18'h30015, 18'h00017, 1'b1, 1'b0, "rerun");
    $display("  %0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule